// File: doc/BRIEF.md
# Glitchless Two-Source Clock Selector

The block takes two free-running clocks and drives one clock out, with a true and a complementary output. A level select input picks the source. When the select changes, the block first holds the output low on the outgoing clock. It then hands over to the incoming clock through a cross-coupled enable handshake, which is synchronised into each clock's own domain. The handover never produces a high or low phase shorter than the source phases. Each source's enable changes only on that source's falling edge, so the gated clock can only open or close while it is low.

A force input covers the case where the outgoing clock has stopped. While the force input is high, the deselected source's enable is cleared asynchronously, so the handover cannot stall. Two asynchronous overrides sit at the output. A gate parks the pair at a level chosen by a park input, and an active-low power-down drives both outputs high and clears both source enables. An asynchronous active-low reset enables source 1.

Top module: `gclk_switch`

## Requirements
- R1: With `sel_i`=1 the output follows `clk_a_i`; with `sel_i`=0 it follows `clk_b_i`, at the same period as the chosen source.
- R2: After a select change, the last high phase of the old source ends within 3 periods of the old clock.
- R3: Once the old source has stopped, the output stays low for no more than 3 periods of the new clock before following it.
- R4: A pulse on `force_i` completes a pending switch even when the old clock is stopped low; without it the output stays low.
- R5: While `gate_i`=1 (and `pwr_ni`=1) the outputs are static, whatever the source clocks do.
- R6: While gated, `park_i`=1 gives `clk_o`=1, `clk_no`=0, and `park_i`=0 gives `clk_o`=0, `clk_no`=1.
- R7: While `pwr_ni`=0, both `clk_o` and `clk_no` are 1.
- R8: When not gated and powered, `clk_no` is always the inverse of `clk_o`.
- R9: During and right after reset, source 1 (`clk_a_i`) is enabled, so the output follows `clk_a_i` with no handshake delay.
- R10: Both source enables are never set at once. No output phase is shorter than half the faster source period.
- R11: After `pwr_ni` returns high, the output resumes the selected source through the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Source clock 1 |
| clk_b_i | input | 1 | Source clock 2 |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Source select: 1 = source 1, 0 = source 2 |
| force_i | input | 1 | Force completion of a pending switch, high pulse |
| gate_i | input | 1 | Asynchronous output disable, active high |
| park_i | input | 1 | Level of the true output while gated |
| pwr_ni | input | 1 | Power-down, active low |
| clk_o | output | 1 | Selected clock, true |
| clk_no | output | 1 | Selected clock, complementary |

## Verification
A stuck or wrongly reset enable flop shows as a missing clock, or as the wrong period, within three cycles of the affected source. If both enables were set, the OR of two gated clocks would produce phases that match neither source period, and the pulse-width monitor catches that on the very next edge. A broken handshake shows as an over-long low gap, or as a short phase, during the switch itself. A broken override shows at once as a wrong static level.

// File: rtl/gclk_pkg.sv
`timescale 1ns/1ps
package gclk_pkg;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic {
    SRC_1 = 1'b0,
    SRC_2 = 1'b1
  } src_e;

  function automatic src_e sel_to_src(input logic sel);
    return sel ? SRC_1 : SRC_2;
  endfunction
endpackage

// File: rtl/gclk_sync_chain.sv
`timescale 1ns/1ps
// Falling-edge shift chain; reset loads INIT, kill clears asynchronously.
module gclk_sync_chain #(
  parameter int unsigned DEPTH = 2,
  parameter bit          INIT  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] stg_q;

  always_ff @(negedge clk_i or negedge rst_ni or posedge kill_i) begin
    if (!rst_ni)      stg_q <= {DEPTH{INIT}};
    else if (kill_i)  stg_q <= '0;
    else              stg_q <= {stg_q[DEPTH-2:0], d_i};
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/gclk_branch.sv
`timescale 1ns/1ps
module gclk_branch #(
  parameter int unsigned DEPTH = 2,
  parameter bit          INIT  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic other_en_i,
  input  logic kill_i,
  output logic en_o,
  output logic gclk_o
);
  logic req;

  // request only once the other source has let go
  assign req = want_i & ~other_en_i;

  gclk_sync_chain #(.DEPTH(DEPTH), .INIT(INIT)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kill_i (kill_i),
    .d_i    (req),
    .q_o    (en_o)
  );

  assign gclk_o = clk_i & en_o;
endmodule

// File: rtl/gclk_out_stage.sv
`timescale 1ns/1ps
module gclk_out_stage #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] gclk_i,
  input  logic         gate_i,
  input  logic         park_i,
  input  logic         pwr_ni,
  output logic         clk_o,
  output logic         clk_no
);
  logic mix;

  assign mix = |gclk_i;

  always_comb begin
    if (!pwr_ni) begin
      clk_o  = 1'b1;
      clk_no = 1'b1;
    end else if (gate_i) begin
      clk_o  = park_i;
      clk_no = ~park_i;
    end else begin
      clk_o  = mix;
      clk_no = ~mix;
    end
  end
endmodule

// File: rtl/gclk_switch.sv
`timescale 1ns/1ps
module gclk_switch
  import gclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic force_i,
  input  logic gate_i,
  input  logic park_i,
  input  logic pwr_ni,
  output logic clk_o,
  output logic clk_no
);
  localparam int unsigned N = NUM_SRC;

  logic [N-1:0] src_clk;
  logic [N-1:0] want;
  logic [N-1:0] kill;
  logic [N-1:0] src_en;
  logic [N-1:0] gclk;
  src_e         cur_src;

  assign src_clk = {clk_b_i, clk_a_i};
  assign cur_src = sel_to_src(sel_i);

  for (genvar i = 0; i < N; i++) begin : g_src
    assign want[i] = (cur_src == src_e'(i));
    assign kill[i] = ~pwr_ni | (force_i & ~want[i]);

    gclk_branch #(.DEPTH(SYNC_STAGES), .INIT(i == 0)) u_branch (
      .clk_i      (src_clk[i]),
      .rst_ni     (rst_ni),
      .want_i     (want[i]),
      .other_en_i (src_en[N-1-i]),
      .kill_i     (kill[i]),
      .en_o       (src_en[i]),
      .gclk_o     (gclk[i])
    );
  end

  gclk_out_stage #(.N(N)) u_out (
    .gclk_i (gclk),
    .gate_i (gate_i),
    .park_i (park_i),
    .pwr_ni (pwr_ni),
    .clk_o  (clk_o),
    .clk_no (clk_no)
  );
endmodule

// File: rtl/gclk_switch_chk.sv
`timescale 1ns/1ps
module gclk_switch_chk (
  input logic       clk_a_i,
  input logic       clk_b_i,
  input logic       rst_ni,
  input logic       gate_i,
  input logic       park_i,
  input logic       pwr_ni,
  input logic       clk_o,
  input logic       clk_no,
  input logic [1:0] src_en
);
  AST_ONE_SRC_A: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !(src_en[0] && src_en[1])); // R10
  AST_ONE_SRC_B: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !(src_en[0] && src_en[1])); // R10
  AST_GATE_PARK: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (pwr_ni && gate_i) |-> (clk_o == park_i && clk_no == !park_i)); // R6
  AST_PD_HIGH: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !pwr_ni |-> (clk_o && clk_no)); // R7
  AST_FOLLOW_A: assert property (@(negedge clk_a_i) disable iff (!rst_ni)
    (src_en[0] && pwr_ni && !gate_i) |-> clk_o); // R1
  AST_COMPL: assert property (@(negedge clk_a_i) disable iff (!rst_ni)
    (pwr_ni && !gate_i) |-> (clk_no == !clk_o)); // R8
endmodule

bind gclk_switch gclk_switch_chk u_chk (
  .clk_a_i (clk_a_i),
  .clk_b_i (clk_b_i),
  .rst_ni  (rst_ni),
  .gate_i  (gate_i),
  .park_i  (park_i),
  .pwr_ni  (pwr_ni),
  .clk_o   (clk_o),
  .clk_no  (clk_no),
  .src_en  (src_en)
);

// File: tb/gclk_switch_tb.sv
`timescale 1ns/1ps
module gclk_switch_tb;
  localparam realtime TA = 10.0;   // 100 MHz source 1
  localparam realtime TB = 14.0;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic run_a = 1'b1;
  logic rst_n = 1'b0, sel = 1'b1, frc = 1'b0, gate = 1'b0, park = 1'b0, pwr_n = 1'b1;
  logic clk_o, clk_no;

  int total = 0, bad = 0;

  gclk_switch u_dut (
    .clk_a_i (clk_a), .clk_b_i (clk_b), .rst_ni (rst_n), .sel_i (sel),
    .force_i (frc), .gate_i (gate), .park_i (park), .pwr_ni (pwr_n),
    .clk_o (clk_o), .clk_no (clk_no)
  );

  always begin #(TA/2); clk_a = run_a ? ~clk_a : 1'b0; end
  always begin #(TB/2); clk_b = ~clk_b; end

  task automatic check(input bit ok, input string req, input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, exp);
    end
  endtask

  // edge bookkeeping and pulse-width monitor
  realtime last_fall = 0.0, last_edge = -1.0, min_pulse = 1000.0;
  bit      mon_en = 1'b0;
  int      rise_cnt = 0;
  always @(negedge clk_o) last_fall = $realtime;
  always @(posedge clk_o) rise_cnt++;
  always @(clk_o) begin
    if (mon_en && last_edge >= 0.0 && ($realtime - last_edge) < min_pulse)
      min_pulse = $realtime - last_edge;
    last_edge = mon_en ? $realtime : -1.0;
  end

  // scoreboard: driver pushes expected periods, monitor measures and compares
  typedef struct { string req; realtime per; } exp_t;
  exp_t sb_q[$];
  event ev_meas;
  bit   meas_done;

  initial begin
    forever begin
      exp_t it;
      realtime t0;
      @(ev_meas);
      it = sb_q.pop_front();
      @(posedge clk_o); t0 = $realtime;
      @(posedge clk_o);
      check(($realtime - t0) > it.per - 0.1 && ($realtime - t0) < it.per + 0.1,
            it.req, $realtime - t0, it.per);
      meas_done = 1'b1;
    end
  end

  task automatic expect_period(input string req, input realtime per);
    exp_t it;
    it.req = req; it.per = per;
    sb_q.push_back(it);
    meas_done = 1'b0;
    -> ev_meas;
    wait (meas_done);
  endtask

  task automatic do_switch(input logic v, input realtime t_old, input realtime t_new);
    realtime ts;
    #1.3;
    ts = $realtime;
    sel = v;
    forever begin
      @(posedge clk_o);
      if ($realtime - last_fall > 8.0) break;
    end
    check((last_fall - ts) <= 3.0*t_old, "R2 old stop", last_fall - ts, 3.0*t_old);
    check(($realtime - last_fall) <= 3.0*t_new, "R3 new start", $realtime - last_fall, 3.0*t_new);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #500us;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R9: source 1 already running during reset
    #12.2;
    check(clk_no == !clk_o, "R8 reset compl", clk_no, !clk_o);
    expect_period("R9 reset src1", TA);
    #3.1 rst_n = 1'b1;
    expect_period("R9 after reset", TA);
    mon_en = 1'b1;

    // R1..R3 switches both ways
    do_switch(1'b0, TA, TB);
    expect_period("R1 src2", TB);
    for (int k = 0; k < 4; k++) begin
      #3.3 check(clk_no == !clk_o, "R8 compl src2", clk_no, !clk_o);
    end
    do_switch(1'b1, TB, TA);
    expect_period("R1 src1", TA);

    // R5/R6 gating
    mon_en = 1'b0;
    #2.1 gate = 1'b1; park = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #7.3;
      check(clk_o == 1'b1, "R5 R6 park hi true", clk_o, 1);
      check(clk_no == 1'b0, "R6 park hi compl", clk_no, 0);
    end
    park = 1'b0;
    for (int k = 0; k < 5; k++) begin
      #7.3;
      check(clk_o == 1'b0, "R5 R6 park lo true", clk_o, 0);
      check(clk_no == 1'b1, "R6 park lo compl", clk_no, 1);
    end
    gate = 1'b0;
    expect_period("R5 ungated", TA);

    // R7/R11 power-down
    #2.1 pwr_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #9.1;
      check(clk_o && clk_no, "R7 pd", {clk_o, clk_no}, 3);
    end
    pwr_n = 1'b1;
    #100;
    expect_period("R11 resume", TA);
    #100 mon_en = 1'b1;

    // R4 dead old clock, then force
    @(negedge clk_a); #1 run_a = 1'b0;
    #20 sel = 1'b0;
    rise_cnt = 0;
    #200;
    check(rise_cnt == 0, "R4 stall without force", rise_cnt, 0);
    frc = 1'b1; #2 frc = 1'b0;
    #80;
    expect_period("R4 forced src2", TB);
    run_a = 1'b1;
    #50;
    do_switch(1'b1, TB, TA);
    expect_period("R4 back to src1", TA);

    #200;
    check(min_pulse >= TA/2 - 0.01, "R10 min pulse", min_pulse, TA/2);
    finish_run();
  end
endmodule